// File: doc/BRIEF.md
# Ping-Pong Line Time Compressor

This block shortens a sampled video line in time by a factor of 4/3 for three parallel components (luma and two colour-difference signals). All logic runs from one 54 MHz clock. Samples are captured into one half of a two-bank line store on every fourth clock, which gives 13.5 MHz. The other bank holds the previous line. That line is played back either on every third clock (18 MHz, compressed) or on every fourth clock (13.5 MHz, same length). A line-start pulse swaps the two banks, so capture of line n overlaps playback of line n-1 and the output always lags the input by one line.

Playback begins on a read-start pulse, which the surrounding timing logic places to set the horizontal position of the shortened picture. Playback ends once it has returned as many samples as the previous line captured. Each returned sample appears as a one-cycle valid pulse, with all three components taken from the same store word.

Top module: `pingpong_line_compressor`

## Requirements
- R1: After reset `valid_o` is low and all three sample outputs are zero, until a line has been captured and a playback started.
- R2: After each line-start pulse, the first input sample is stored on the clock edge that follows the edge that sampled the pulse. Further samples are stored every 4th clock after that, at consecutive addresses from 0, up to CAP_LEN samples (662 by default). Any later samples in that line are discarded.
- R3: Each line-start pulse swaps the roles of the two banks. Playback returns the samples of the line that ended at that pulse, in capture order, while the new line is being written into the other bank.
- R4: A playback returns exactly as many samples as the previous line stored. A read-start pulse has no effect when that count is zero, as it is for the first line after reset.
- R5: With `rate_sel_i` = 1 at read start (compressed), samples come out every 3rd clock. The first `valid_o` pulse follows one clock after the edge that sampled `rd_start_i`.
- R6: With `rate_sel_i` = 0 at read start (same rate), samples come out every 4th clock, with the same first-sample latency as R5.
- R7: `rate_sel_i` is sampled only when a playback starts. Changing it during a playback does not change that playback's spacing.
- R8: A read-start pulse while a playback is running is ignored. The running playback continues unchanged.
- R9: A line-start pulse ends any running playback. No `valid_o` pulse occurs in the cycle after it, and no further samples of the interrupted line are produced.
- R10: `valid_o` is a one-cycle pulse per sample. All sample outputs are zero whenever `valid_o` is low.
- R11: The three components of one sample are written and read as one word, so they always appear together on the same `valid_o` pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 54 MHz line-locked clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_start_i | input | 1 | One-cycle pulse marking the start of an input line |
| rd_start_i | input | 1 | One-cycle pulse starting playback of the previous line |
| rate_sel_i | input | 1 | Playback rate: 1 = every 3rd clock, 0 = every 4th clock |
| y_i | input | 8 | Luma input sample |
| cb_i | input | 8 | Blue colour-difference input sample |
| cr_i | input | 8 | Red colour-difference input sample |
| y_o | output | 8 | Luma output sample |
| cb_o | output | 8 | Blue colour-difference output sample |
| cr_o | output | 8 | Red colour-difference output sample |
| valid_o | output | 1 | One-cycle pulse for each output sample |

## Verification
Several properties are checked on every cycle: the sample outputs stay at zero between pulses, no pulse follows a line start, valid pulses of one playback are never closer than three clocks apart, the banks swap on every line start, and neither the write count nor the read address passes its limit. Other behaviours can only be shown by the bench's line sequences. These are the exact contents and order of a replayed line, the first-sample latency, the choice between 3- and 4-clock spacing and how that choice is latched, the ignored second read start, and the count of samples left over when a short line cuts a playback off.

// File: rtl/pingpong_pkg.sv
package pingpong_pkg;

  localparam int NUM_CH = 3;

  typedef enum logic {
    RATE_SAME = 1'b0,
    RATE_FAST = 1'b1
  } rd_rate_e;

endpackage

// File: rtl/pp_rate_div.sv
module pp_rate_div #(
  parameter int PERIOD_W = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                restart,
  input  logic                run,
  input  logic [PERIOD_W-1:0] period,
  output logic                tick
);

  logic [PERIOD_W-1:0] phase_q, phase_d;

  always_comb begin
    phase_d = phase_q;
    if (restart) begin
      phase_d = '0;
    end else if (run) begin
      if (phase_q == period - 1'b1) phase_d = '0;
      else                          phase_d = phase_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= '0;
    else        phase_q <= phase_d;
  end

  assign tick = run & (phase_q == '0);

endmodule

// File: rtl/pp_write_ctrl.sv
module pp_write_ctrl #(
  parameter int CAP_LEN = 662,
  parameter int CW      = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          line_start,
  input  logic          tick,
  output logic          wr_on,
  output logic          wr_en,
  output logic          wr_bank,
  output logic [CW-1:0] wr_cnt
);

  logic          on_q, on_d;
  logic          bank_q, bank_d;
  logic [CW-1:0] cnt_q, cnt_d;

  assign wr_en = tick & ~line_start & (cnt_q < CW'(CAP_LEN));

  always_comb begin
    on_d   = on_q;
    bank_d = bank_q;
    cnt_d  = cnt_q;
    if (line_start) begin
      on_d   = 1'b1;
      bank_d = ~bank_q;
      cnt_d  = '0;
    end else if (wr_en) begin
      cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      on_q   <= 1'b0;
      bank_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      on_q   <= on_d;
      bank_q <= bank_d;
      cnt_q  <= cnt_d;
    end
  end

  assign wr_on   = on_q;
  assign wr_bank = bank_q;
  assign wr_cnt  = cnt_q;

endmodule

// File: rtl/pp_read_ctrl.sv
module pp_read_ctrl
  import pingpong_pkg::*;
#(
  parameter int CW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          line_start,
  input  logic          rd_start,
  input  logic          rate_sel,
  input  logic          tick,
  input  logic          wr_bank,
  input  logic [CW-1:0] wr_cnt,
  output logic          accept,
  output logic          rd_on,
  output rd_rate_e      rd_mode,
  output logic          rd_en,
  output logic          rd_bank,
  output logic [CW-1:0] rd_cnt,
  output logic [CW-1:0] rd_len
);

  logic          on_q, on_d;
  rd_rate_e      mode_q, mode_d;
  logic          bank_q, bank_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] len_q, len_d;

  assign accept = rd_start & ~line_start & ~on_q & (len_q != '0);
  assign rd_en  = tick & on_q & ~line_start;

  always_comb begin
    on_d   = on_q;
    mode_d = mode_q;
    bank_d = bank_q;
    cnt_d  = cnt_q;
    len_d  = len_q;
    if (line_start) begin
      on_d   = 1'b0;
      bank_d = wr_bank;
      len_d  = wr_cnt;
    end else if (accept) begin
      on_d   = 1'b1;
      cnt_d  = '0;
      mode_d = rd_rate_e'(rate_sel);
    end else if (rd_en) begin
      cnt_d  = cnt_q + 1'b1;
      if (cnt_q == len_q - 1'b1) on_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      on_q   <= 1'b0;
      mode_q <= RATE_SAME;
      bank_q <= 1'b0;
      cnt_q  <= '0;
      len_q  <= '0;
    end else begin
      on_q   <= on_d;
      mode_q <= mode_d;
      bank_q <= bank_d;
      cnt_q  <= cnt_d;
      len_q  <= len_d;
    end
  end

  assign rd_on   = on_q;
  assign rd_mode = mode_q;
  assign rd_bank = bank_q;
  assign rd_cnt  = cnt_q;
  assign rd_len  = len_q;

endmodule

// File: rtl/pp_line_store.sv
module pp_line_store #(
  parameter int WORD_W = 24,
  parameter int DEPTH  = 1024,
  parameter int AW     = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_bank,
  input  logic [AW-1:0]     wr_addr,
  input  logic [WORD_W-1:0] wr_word,
  input  logic              rd_en,
  input  logic              rd_bank,
  input  logic [AW-1:0]     rd_addr,
  output logic [WORD_W-1:0] rd_word,
  output logic              rd_valid
);

  localparam int ENTRIES = 2 * DEPTH;

  logic [WORD_W-1:0] mem [ENTRIES];
  logic [WORD_W-1:0] word_q, word_d;
  logic              valid_q, valid_d;

  always_ff @(posedge clk) begin
    if (wr_en) mem[{wr_bank, wr_addr}] <= wr_word;
  end

  always_comb begin
    valid_d = rd_en;
    word_d  = '0;
    if (rd_en) word_d = mem[{rd_bank, rd_addr}];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      word_q  <= word_d;
      valid_q <= valid_d;
    end
  end

  assign rd_word  = word_q;
  assign rd_valid = valid_q;

endmodule

// File: rtl/pingpong_line_compressor.sv
module pingpong_line_compressor
  import pingpong_pkg::*;
#(
  parameter int SAMPLE_W    = 8,
  parameter int DEPTH       = 1024,
  parameter int CAP_LEN     = 662,
  parameter int WR_DIV      = 4,
  parameter int RD_DIV_FAST = 3,
  parameter int RD_DIV_SAME = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                line_start_i,
  input  logic                rd_start_i,
  input  logic                rate_sel_i,
  input  logic [SAMPLE_W-1:0] y_i,
  input  logic [SAMPLE_W-1:0] cb_i,
  input  logic [SAMPLE_W-1:0] cr_i,
  output logic [SAMPLE_W-1:0] y_o,
  output logic [SAMPLE_W-1:0] cb_o,
  output logic [SAMPLE_W-1:0] cr_o,
  output logic                valid_o
);

  localparam int AW     = $clog2(DEPTH);
  localparam int CW     = $clog2(CAP_LEN + 1);
  localparam int WORD_W = NUM_CH * SAMPLE_W;
  localparam int MAX_A  = (WR_DIV > RD_DIV_FAST) ? WR_DIV : RD_DIV_FAST;
  localparam int MAX_D  = (MAX_A > RD_DIV_SAME) ? MAX_A : RD_DIV_SAME;
  localparam int PW     = $clog2(MAX_D + 1);

  logic [SAMPLE_W-1:0] ch_in  [NUM_CH];
  logic [SAMPLE_W-1:0] ch_out [NUM_CH];
  logic [WORD_W-1:0]   wr_word, rd_word;

  assign ch_in[0] = y_i;
  assign ch_in[1] = cb_i;
  assign ch_in[2] = cr_i;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    assign wr_word[(NUM_CH-1-c)*SAMPLE_W +: SAMPLE_W] = ch_in[c];
    assign ch_out[c] = rd_word[(NUM_CH-1-c)*SAMPLE_W +: SAMPLE_W];
  end

  assign y_o  = ch_out[0];
  assign cb_o = ch_out[1];
  assign cr_o = ch_out[2];

  logic          wr_on, wr_tick, wr_en, wr_bank;
  logic [CW-1:0] wr_cnt;
  logic          rd_accept, rd_on, rd_tick, rd_en, rd_bank;
  rd_rate_e      rd_mode;
  logic [CW-1:0] rd_cnt, rd_len;
  logic [PW-1:0] rd_period;

  assign rd_period = (rd_mode == RATE_FAST) ? PW'(RD_DIV_FAST) : PW'(RD_DIV_SAME);

  pp_rate_div #(.PERIOD_W(PW)) i_wr_div (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (line_start_i),
    .run     (wr_on),
    .period  (PW'(WR_DIV)),
    .tick    (wr_tick)
  );

  pp_write_ctrl #(.CAP_LEN(CAP_LEN), .CW(CW)) i_wr_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .line_start (line_start_i),
    .tick       (wr_tick),
    .wr_on      (wr_on),
    .wr_en      (wr_en),
    .wr_bank    (wr_bank),
    .wr_cnt     (wr_cnt)
  );

  pp_rate_div #(.PERIOD_W(PW)) i_rd_div (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (rd_accept),
    .run     (rd_on),
    .period  (rd_period),
    .tick    (rd_tick)
  );

  pp_read_ctrl #(.CW(CW)) i_rd_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .line_start (line_start_i),
    .rd_start   (rd_start_i),
    .rate_sel   (rate_sel_i),
    .tick       (rd_tick),
    .wr_bank    (wr_bank),
    .wr_cnt     (wr_cnt),
    .accept     (rd_accept),
    .rd_on      (rd_on),
    .rd_mode    (rd_mode),
    .rd_en      (rd_en),
    .rd_bank    (rd_bank),
    .rd_cnt     (rd_cnt),
    .rd_len     (rd_len)
  );

  pp_line_store #(.WORD_W(WORD_W), .DEPTH(DEPTH), .AW(AW)) i_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_bank  (wr_bank),
    .wr_addr  (AW'(wr_cnt)),
    .wr_word  (wr_word),
    .rd_en    (rd_en),
    .rd_bank  (rd_bank),
    .rd_addr  (AW'(rd_cnt)),
    .rd_word  (rd_word),
    .rd_valid (valid_o)
  );

endmodule

// File: rtl/pp_checker.sv
module pp_checker #(
  parameter int SAMPLE_W = 8,
  parameter int CAP_LEN  = 662,
  parameter int CW       = 10
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  line_start_i,
  input logic                  rd_start_i,
  input logic                  valid_o,
  input logic [3*SAMPLE_W-1:0] out_word,
  input logic                  wr_en,
  input logic                  wr_bank,
  input logic [CW-1:0]         wr_cnt,
  input logic                  rd_en,
  input logic [CW-1:0]         rd_cnt,
  input logic [CW-1:0]         rd_len
);

  logic [2:0] gap_q;
  logic       seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q  <= '0;
      seen_q <= 1'b0;
    end else begin
      if (valid_o)              gap_q <= 3'd1;
      else if (gap_q != 3'd7)   gap_q <= gap_q + 3'd1;
      if (line_start_i || rd_start_i) seen_q <= 1'b0;
      else if (valid_o)               seen_q <= 1'b1;
    end
  end

  AST_WR_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_cnt < CW'(CAP_LEN))); // R2

  AST_BANK_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
    line_start_i |=> (wr_bank != $past(wr_bank))); // R3

  AST_RD_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> (rd_cnt < rd_len)); // R4

  AST_RATE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && seen_q) |-> (gap_q >= 3'd3)); // R5

  AST_LINE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    line_start_i |=> !valid_o); // R9

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_o |-> (out_word == '0)); // R10

  AST_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o); // R10

endmodule

bind pingpong_line_compressor pp_checker #(
  .SAMPLE_W (SAMPLE_W),
  .CAP_LEN  (CAP_LEN),
  .CW       (CW)
) i_pp_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .line_start_i (line_start_i),
  .rd_start_i   (rd_start_i),
  .valid_o      (valid_o),
  .out_word     ({y_o, cb_o, cr_o}),
  .wr_en        (wr_en),
  .wr_bank      (wr_bank),
  .wr_cnt       (wr_cnt),
  .rd_en        (rd_en),
  .rd_cnt       (rd_cnt),
  .rd_len       (rd_len)
);

// File: tb/test_pingpong_line_compressor.sv
module test_pingpong_line_compressor;

  localparam int CAP = 662;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic line_start_i = 1'b0, rd_start_i = 1'b0, rate_sel_i = 1'b0;
  logic [7:0] y_i = '0, cb_i = '0, cr_i = '0;
  logic [7:0] y_o, cb_o, cr_o;
  logic valid_o;

  always #10 clk = ~clk;

  pingpong_line_compressor i_pingpong_line_compressor (
    .clk(clk), .rst_n(rst_n), .line_start_i(line_start_i), .rd_start_i(rd_start_i),
    .rate_sel_i(rate_sel_i), .y_i(y_i), .cb_i(cb_i), .cr_i(cr_i),
    .y_o(y_o), .cb_o(cb_o), .cr_o(cr_o), .valid_o(valid_o)
  );

  int checks = 0, fails = 0;
  int cyc = 0;
  int line_no = 0;
  int rd_edge = 0, exp_period = 4, last_valid = 0, idle_bad = 0;
  bit first_pending = 0, done = 0;
  logic [23:0] cur_line[$];
  logic [23:0] exp_q[$];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  // monitor: pops scoreboard entries as samples appear
  always @(posedge clk) begin
    #2;
    if (rst_n) begin
      if (valid_o) begin
        if (exp_q.size() == 0) begin
          chk(0, "R4 sample with nothing queued", 1, 0);
        end else begin
          logic [23:0] e;
          e = exp_q.pop_front();
          chk({y_o, cb_o, cr_o} == e, "R3 R11 replayed word", int'({y_o, cb_o, cr_o}), int'(e));
        end
        if (first_pending)
          chk(cyc == rd_edge + 1, "R5 R6 first sample latency", cyc, rd_edge + 1);
        else
          chk(cyc - last_valid == exp_period, "R5 R6 R7 sample spacing", cyc - last_valid, exp_period);
        first_pending = 0;
        last_valid = cyc;
      end else if ({y_o, cb_o, cr_o} != 24'd0) begin
        idle_bad++;
      end
    end
  end

  function automatic logic [23:0] pix(input int ln, input int j);
    return {8'(ln * 37 + j * 3), 8'(j * 5 + ln), ~8'(j + ln * 11)};
  endfunction

  // driver: one input line, optional playback of the previous line
  task automatic run_line(input int ncyc, input int rd_at, input bit mode,
                          input int toggle_at, input int rd_again, input int exp_left);
    @(negedge clk);
    chk(exp_q.size() == exp_left, "R4 R9 samples left from previous playback", exp_q.size(), exp_left);
    chk(idle_bad == 0, "R10 outputs zero between pulses", idle_bad, 0);
    idle_bad = 0;
    exp_q = cur_line;
    cur_line = {};
    line_no++;
    line_start_i = 1'b1;
    rd_start_i = 1'b0;
    rate_sel_i = mode;
    {y_i, cb_i, cr_i} = pix(line_no, 0);
    for (int j = 1; j < ncyc; j++) begin
      @(negedge clk);
      line_start_i = 1'b0;
      {y_i, cb_i, cr_i} = pix(line_no, j);
      if (((j - 1) % 4 == 0) && cur_line.size() < CAP) cur_line.push_back(pix(line_no, j));
      rd_start_i = (j == rd_at) || (j == rd_again);
      if (j == rd_at) begin
        rd_edge = cyc + 1;
        first_pending = 1;
        exp_period = mode ? 3 : 4;
      end
      if (j == toggle_at) rate_sel_i = ~mode;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(valid_o == 1'b0, "R1 valid low in reset", valid_o, 0);
    chk({y_o, cb_o, cr_o} == 24'd0, "R1 outputs zero in reset", int'({y_o, cb_o, cr_o}), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(valid_o == 1'b0, "R1 valid low after reset", valid_o, 0);
    // first line: nothing stored yet, read start must do nothing (R4)
    run_line(2800, 10, 1'b1, -1, -1, 0);
    // full line capped at CAP (R2), compressed playback (R5)
    run_line(2800, 20, 1'b1, -1, -1, 0);
    // short line cuts off a same-rate playback (R6, R9)
    run_line(400, 5, 1'b0, -1, -1, 0);
    // compressed playback of short line, rate input toggled mid-read (R7)
    run_line(2800, 30, 1'b1, 100, -1, CAP - 99);
    // same-rate playback with a second read start mid-read (R8)
    run_line(2800, 15, 1'b0, -1, 300, 0);
    // line with no playback
    run_line(200, -1, 1'b0, -1, -1, 0);
    @(negedge clk);
    chk(exp_q.size() == CAP, "R3 R4 unread line untouched", exp_q.size(), CAP);
    chk(idle_bad == 0, "R10 outputs zero between pulses", idle_bad, 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule